// File: doc/BRIEF.md
# Instruction Prefetch Buffer

This block sits between a processor's decode stage and a single memory bus port that is also used for data loads and stores. It fetches aligned 32-bit words ahead of execution and keeps up to three of them. Decode receives one 16-bit instruction at a time, with its address: first the low half of a word, then the high half. A data access always takes the bus ahead of a fetch. While a data access is under way, decode keeps drawing on the words already held.

Fetching is speculative and there is no prediction. A redirect from the branch logic empties the buffer and restarts fetching at the word that holds the target. If the target is halfword-aligned, the first word delivers only its upper half. A fetch that is still on the bus when a redirect arrives is marked stale, and the word it returns is thrown away. The bus may take any number of cycles per transfer. A transfer finishes in the cycle the memory raises ready.

Top module: `prefetch_queue`

## Requirements
- R1: After reset `dec_valid` is 0. The first bus transfer is a fetch of `RESET_PC`, which starts on the first clock edge after reset is released.
- R2: The 16-bit instruction at halfword address A is bits 15:0 of the word at A with bits 1:0 cleared when A[1]=0, and bits 31:16 of that word when A[1]=1. Each instruction decode accepts (with `dec_req` and `dec_valid` both high at a clock edge) moves `dec_pc` on by 2, so instructions come out in strictly ascending address order.
- R3: No more than `DEPTH` (3) words are held at once. Fetches still in flight count toward that limit. When decode takes nothing, fetching stops after exactly three words and `bus_req` goes low.
- R4: When the bus is free and a data request and a fetch are both pending, the data transfer starts: `bus_addr` shows `dat_addr` and `bus_we` shows `dat_we`.
- R5: While a data transfer holds the bus, decode keeps receiving buffered instructions with `dec_valid` high.
- R6: When the buffer is empty, `dec_valid` is low and `dec_pc` holds its value, however long `dec_req` stays high.
- R7: In the cycle after `redirect_valid`, `dec_valid` is 0 and `dec_pc` equals the target. The next fetch goes to the target with bits 1:0 cleared, and no fetch starts in the redirect cycle itself.
- R8: A word returned by a fetch that was on the bus when a redirect occurred is never delivered.
- R9: A target with bit 1 set delivers the upper half of its first word as the first instruction, then goes on from the following word.
- R10: `bus_req`, `bus_addr` and `bus_we` stay steady from the start of a transfer until the cycle in which `bus_ready` is high.
- R11: A data transfer ends with `dat_done` high for the single cycle in which `bus_ready` is high, and `dat_rdata` carries `bus_rdata` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_valid | input | 1 | Branch redirect strobe |
| redirect_addr | input | AW | Redirect target (halfword address) |
| dec_req | input | 1 | Decode ready to take an instruction |
| dec_valid | output | 1 | An instruction is available |
| dec_instr | output | 16 | Instruction at `dec_pc` |
| dec_pc | output | AW | Address of `dec_instr` |
| dat_req | input | 1 | Data access request, held until `dat_done` |
| dat_we | input | 1 | Data access is a write |
| dat_addr | input | AW | Data address |
| dat_wdata | input | 32 | Data write value |
| dat_rdata | output | 32 | Data read value, valid with `dat_done` |
| dat_done | output | 1 | Data access completes this cycle |
| bus_req | output | 1 | Bus transfer active |
| bus_we | output | 1 | Bus transfer is a write |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 32 | Bus write value |
| bus_rdata | input | 32 | Bus read value, valid with `bus_ready` |
| bus_ready | input | 1 | Bus transfer completes this cycle |

## Verification
The bench memory returns, for each halfword, that halfword's own address. Any word placed in the wrong slot, or a half taken from the wrong side of a word, therefore shows up as an instruction that differs from its `dec_pc`. The harder cases are covered one by one. A stale fetch overtaken by a redirect would surface as an old address delivered under the new `dec_pc`. A halfword-aligned target handled wrongly would hand out the low half first. A design that ignored in-flight fetches when checking for room would fetch a fourth word. A wrong arbiter would put the fetch address on the bus when a data request arrives in the cycle after a redirect. The bench also holds a fetch on the bus indefinitely to drain the buffer and confirm the stall, and keeps a slow data read on the bus while checking that decode is still fed.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int AW = 32,
  parameter int DEPTH = 3,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect_valid,
  input  logic [AW-1:0] redirect_addr,
  input  logic          dec_req,
  output logic          dec_valid,
  output logic [15:0]   dec_instr,
  output logic [AW-1:0] dec_pc,
  input  logic          dat_req,
  input  logic          dat_we,
  input  logic [AW-1:0] dat_addr,
  input  logic [31:0]   dat_wdata,
  output logic [31:0]   dat_rdata,
  output logic          dat_done,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ready
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0]   slot [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic [AW-1:0] fetch_pc;
  logic          busy, own_data, tx_cur;
  logic [AW-1:0] tx_addr;
  logic          tx_we;
  logic [31:0]   tx_wdata;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire           free_bus   = !busy || bus_ready;
  wire           fetch_ret  = busy && bus_ready && !own_data;
  wire           fill       = fetch_ret && tx_cur && !redirect_valid;
  wire           inflight   = busy && !own_data && tx_cur;
  wire [CW:0]    occ        = {1'b0, count} + {{CW{1'b0}}, inflight};
  wire           take       = dec_req && dec_valid && !redirect_valid;
  wire           pop        = take && dec_pc[1];
  wire           start_data = free_bus && dat_req && !dat_done;
  wire           start_fetch = free_bus && !start_data && !redirect_valid &&
                               (occ < (CW+1)'(DEPTH));

  assign dec_valid = (count != '0);
  assign dec_instr = dec_pc[1] ? slot[rd_ptr][31:16] : slot[rd_ptr][15:0];
  assign dat_done  = busy && own_data && bus_ready;
  assign dat_rdata = bus_rdata;
  assign bus_req   = busy;
  assign bus_we    = busy && own_data && tx_we;
  assign bus_addr  = tx_addr;
  assign bus_wdata = tx_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      own_data <= 1'b0;
      tx_cur   <= 1'b0;
      tx_addr  <= '0;
      tx_we    <= 1'b0;
      tx_wdata <= '0;
      fetch_pc <= {RESET_PC[AW-1:2], 2'b00};
    end else begin
      if (free_bus) busy <= start_data || start_fetch;
      if (redirect_valid) begin
        tx_cur   <= 1'b0;
        fetch_pc <= {redirect_addr[AW-1:2], 2'b00};
      end
      if (start_data) begin
        own_data <= 1'b1;
        tx_addr  <= dat_addr;
        tx_we    <= dat_we;
        tx_wdata <= dat_wdata;
      end else if (start_fetch) begin
        own_data <= 1'b0;
        tx_cur   <= 1'b1;
        tx_addr  <= fetch_pc;
        tx_we    <= 1'b0;
        fetch_pc <= fetch_pc + AW'(4);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      dec_pc <= RESET_PC;
    end else if (redirect_valid) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      dec_pc <= redirect_addr;
    end else begin
      if (fill) wr_ptr <= bump(wr_ptr);
      if (pop) rd_ptr <= bump(rd_ptr);
      if (take) dec_pc <= dec_pc + AW'(2);
      count <= count + CW'(fill) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (fill) slot[wr_ptr] <= bus_rdata;
  end

  // R3
  occ_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (CW+1)'(DEPTH));

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (!dec_valid && dec_pc == $past(redirect_addr)));

  // R4
  data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!bus_req || bus_ready) && dat_req && !dat_done) |=>
      (bus_req && bus_addr == $past(dat_addr)));

  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !dec_valid && !redirect_valid) |=> $stable(dec_pc));
endmodule

// File: tb/prefetch_queue_bench.sv
`timescale 1ns/1ps
module prefetch_queue_bench;
  localparam logic [31:0] START = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redirect_valid = 1'b0;
  logic [31:0] redirect_addr = '0;
  logic        dec_req = 1'b0;
  logic        dec_valid;
  logic [15:0] dec_instr;
  logic [31:0] dec_pc;
  logic        dat_req = 1'b0, dat_we = 1'b0;
  logic [31:0] dat_addr = '0, dat_wdata = '0;
  logic [31:0] dat_rdata;
  logic        dat_done;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_ready = 1'b0;

  int checks = 0, fails = 0;
  int lat = 0, wc = 0;
  int fetch_done = 0, hold_err = 0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;
  logic        done_seen = 1'b0;
  logic [31:0] done_data = '0;
  logic [31:0] exp_pc;

  always #2.5 clk = ~clk;

  prefetch_queue #(.AW(32), .DEPTH(3), .RESET_PC(START)) u_prefetch_queue (
    .clk(clk), .rst_n(rst_n),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .dec_req(dec_req), .dec_valid(dec_valid), .dec_instr(dec_instr), .dec_pc(dec_pc),
    .dat_req(dat_req), .dat_we(dat_we), .dat_addr(dat_addr), .dat_wdata(dat_wdata),
    .dat_rdata(dat_rdata), .dat_done(dat_done),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [15:0] lo;
    lo = {a[15:2], 2'b00};
    return {lo + 16'd2, lo};
  endfunction

  assign bus_rdata = mem_word(bus_addr);

  always @(negedge clk) begin
    if (!bus_req) begin
      wc = 0;
      bus_ready <= 1'b0;
    end else begin
      if (bus_ready) wc = 0;
      bus_ready <= (wc >= lat);
      wc = wc + 1;
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_wait && (!bus_req || bus_addr != prev_addr)) hold_err++;
      if (bus_req && bus_ready && !bus_addr[31]) fetch_done++;
      if (dat_done) begin
        done_seen <= 1'b1;
        done_data <= dat_rdata;
      end
      prev_wait <= bus_req && !bus_ready;
      prev_addr <= bus_addr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic take(input int n, input string req);
    int got = 0;
    int guard = 0;
    dec_req = 1'b1;
    while (got < n && guard < 400) begin
      if (dec_valid) begin
        chk(req, dec_pc, exp_pc);
        chk(req, {16'h0, dec_instr}, {16'h0, exp_pc[15:0]});
        exp_pc += 2;
        got++;
      end
      step();
      guard++;
    end
    dec_req = 1'b0;
    chk(req, got, n);
  endtask

  task automatic redirect(input logic [31:0] tgt);
    redirect_valid = 1'b1;
    redirect_addr = tgt;
    step();
    redirect_valid = 1'b0;
    exp_pc = tgt;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done_seen && guard < 200) begin step(); guard++; end
    dat_req = 1'b0;
    done_seen = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", dec_valid, 0);
    chk("R1 no bus before edge", bus_req, 0);
    step();
    chk("R1 first fetch req", bus_req, 1);
    chk("R1 first fetch addr", bus_addr, START);
    exp_pc = START;
  endtask

  task automatic t_fill();
    lat = 2;
    repeat (30) step();
    chk("R3 words fetched", fetch_done, 3);
    chk("R3 bus idle when full", bus_req, 0);
    chk("R3 first instr ready", dec_valid, 1);
    chk("R10 bus held until ready", hold_err, 0);
  endtask

  task automatic t_stream();
    take(10, "R2 stream");
  endtask

  task automatic t_stall();
    int guard = 0;
    lat = 1000000;
    dec_req = 1'b1;
    while (dec_valid && guard < 50) begin
      chk("R2 drain", dec_pc, exp_pc);
      exp_pc += 2;
      step();
      guard++;
    end
    repeat (5) begin
      step();
      chk("R6 empty stalls", dec_valid, 0);
      chk("R6 pc holds", dec_pc, exp_pc);
    end
    dec_req = 1'b0;
    lat = 1;
    take(4, "R6 resume");
  endtask

  task automatic t_overlap();
    lat = 0;
    repeat (12) step();
    lat = 8;
    dat_req = 1'b1; dat_we = 1'b0; dat_addr = 32'h8000_0040;
    step();
    chk("R4 data on bus", bus_addr, 32'h8000_0040);
    dec_req = 1'b1;
    repeat (4) begin
      chk("R5 fed during data", dec_valid, 1);
      chk("R5 data still on bus", bus_addr[31], 1);
      chk("R5 instr", {16'h0, dec_instr}, {16'h0, exp_pc[15:0]});
      exp_pc += 2;
      step();
    end
    dec_req = 1'b0;
    wait_done();
    chk("R11 read data", done_data, mem_word(32'h8000_0040));
  endtask

  task automatic t_prio();
    lat = 0;
    repeat (12) step();
    chk("R3 full and idle", bus_req, 0);
    redirect(32'h0000_2002);
    chk("R7 flushed", dec_valid, 0);
    chk("R7 pc at target", dec_pc, 32'h0000_2002);
    chk("R7 no fetch in redirect cycle", bus_req, 0);
    dat_req = 1'b1; dat_we = 1'b1; dat_addr = 32'h8000_0080; dat_wdata = 32'h1234_5678;
    step();
    chk("R4 data wins", bus_addr, 32'h8000_0080);
    chk("R4 write flag", bus_we, 1);
    chk("R4 write data", bus_wdata, 32'h1234_5678);
    wait_done();
    chk("R7 refetch word addr", bus_addr, 32'h0000_2000);
    chk("R7 refetch is read", bus_we, 0);
    take(3, "R9 halfword target");
  endtask

  task automatic t_kill();
    lat = 4;
    repeat (10) step();
    redirect(32'h0000_3000);
    step();
    chk("R7 fetch at target", bus_addr, 32'h0000_3000);
    chk("R8 fetch in flight", bus_req, 1);
    redirect(32'h0000_4000);
    take(4, "R8 stale word dropped");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fill();
    t_stream();
    t_stall();
    t_overlap();
    t_prio();
    t_kill();
    chk("R10 bus held until ready", hold_err, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule